// File: doc/BRIEF.md
# Reset and Clock Start-Up Sequencer

This block keeps the system in reset after any reset event. It releases the system only when the supply is good and the chosen clock has gone through its start-up phases. Each event falls into one of two classes. A cold event is a power-on strobe, a brown-out strobe or a low supply-good input. Every other cause is a warm event, including a software reset instruction; these arrive on a vector of warm-cause strobes. After a cold event the active clock-source code is reloaded from the configuration input. After a warm event the code held in the current-source register stays as it is.

Once the cause inputs are quiet, the sequencer steps through a chain of delay phases that depends on the source. Every mode starts with a start-up delay counted in reference ticks. Crystal modes then add a start-up timer of a fixed number of oscillator edges. PLL modes end with a lock wait, also counted in reference ticks. The oscillator edges arrive as single-cycle strobes in the block's own clock domain. The reset output comes from a register. A status flag reports the class of the last reset.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `rstclk_sequencer`

## Requirements
- R1: A cold event (`por_i`, `bor_i`, or `supply_ok_i` low) sets `cold_rst_o` to 1 on the next edge. On the first cycle after the cause inputs go quiet, `cur_src_o` takes the value of `cfg_src_i`.
- R2: A warm event (any bit of `warm_i` high, with no cold cause and no pending reload) sets `cold_rst_o` to 0 and leaves `cur_src_o` unchanged, whatever `cfg_src_i` holds.
- R3: A cold cause in the same cycle as a warm cause is handled as cold. A warm event that arrives while a cold reload is still pending does not cancel the reload or clear `cold_rst_o`.
- R4: `sys_rst_o` is 1 on the edge after any reset event. It stays 1 as long as `supply_ok_i` is low.
- R5: Source codes 0 (fast RC), 5 (low-power RC), 6 (fast RC divided by 16), 7 (fast RC with programmable divider), and code 2 (primary) with `prim_xtal_i`=0 (external clock) need only the start-up delay. `sys_rst_o` falls on the edge that samples the OSCD_TICKS-th `ref_tick_i` after the sequence starts.
- R6: Code 4 (secondary crystal), and code 2 with `prim_xtal_i`=1, add a start-up timer of OST_EDGES `osc_edge_i` strobes after the start-up delay.
- R7: Code 1 (fast RC with PLL) adds LOCK_TICKS `ref_tick_i` strobes of lock wait after the start-up delay. Code 3 (primary with PLL) adds the start-up timer, when `prim_xtal_i`=1, and then the lock wait.
- R8: A reset event during any delay phase restarts the sequence from the start-up delay. An event in the same cycle as the final counting strobe wins, and `sys_rst_o` stays 1.
- R9: After the asynchronous reset `rst_ni`: `sys_rst_o`=1, `cold_rst_o`=1 and `cur_src_o`=0. The first sequence that follows loads `cfg_src_i`, as for a cold event.
- R10: A strobe that does not belong to the current phase is ignored. Examples are `osc_edge_i` during the start-up delay or the lock wait, `ref_tick_i` during the start-up timer, and any strobe while the block waits for the supply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| por_i | input | 1 | Power-on reset strobe (cold) |
| bor_i | input | 1 | Brown-out reset strobe (cold) |
| warm_i | input | N_WARM | Warm reset cause strobes, one per source (software reset included) |
| supply_ok_i | input | 1 | Supply good; low forces a cold reset |
| cfg_src_i | input | 3 | Configured clock-source code, loaded on cold reset |
| prim_xtal_i | input | 1 | 1: primary source is a crystal; 0: external clock |
| ref_tick_i | input | 1 | Reference tick strobe for start-up delay and lock wait |
| osc_edge_i | input | 1 | Oscillator edge strobe for the start-up timer |
| sys_rst_o | output | 1 | Registered system reset, active high |
| cur_src_o | output | 3 | Active clock-source code |
| cold_rst_o | output | 1 | 1 if the last reset was cold, 0 if warm |

## Verification
Two functions can act in the same cycle. Cause classification and phase counting meet when a reset event lands on the edge that samples the last tick of a phase. Cold and warm classification meet when both kinds of cause are raised together, or when a warm cause follows a cold one before the reload. The bench drives each of these collisions at one negative clock edge so that a single rising edge samples both. It then checks that reset is still held and that a full sequence follows. The scoreboard compares the source code and the cold/warm flag at the release against values the bench worked out in advance, which show the precedence that took effect.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  localparam int unsigned SRC_W = 3;
  typedef logic [SRC_W-1:0] src_t;

  typedef enum logic [2:0] {
    PH_SUPPLY = 3'd0,
    PH_OSCD   = 3'd1,
    PH_OST    = 3'd2,
    PH_LOCK   = 3'd3,
    PH_RUN    = 3'd4
  } phase_e;

  localparam src_t SRC_FRC_PLL = 3'd1;
  localparam src_t SRC_PRI     = 3'd2;
  localparam src_t SRC_PRI_PLL = 3'd3;
  localparam src_t SRC_SEC     = 3'd4;

  function automatic logic src_uses_pll(input src_t s);
    return (s == SRC_FRC_PLL) || (s == SRC_PRI_PLL);
  endfunction

  function automatic logic src_uses_ost(input src_t s, input logic xtal);
    return (s == SRC_SEC) || (((s == SRC_PRI) || (s == SRC_PRI_PLL)) && xtal);
  endfunction

endpackage

// File: rtl/rcs_cause_ctl.sv
module rcs_cause_ctl import rcs_pkg::*; #(
  parameter int unsigned N_WARM = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic              bor_i,
  input  logic              supply_ok_i,
  input  logic [N_WARM-1:0] warm_i,
  input  logic              load_i,
  input  src_t              cfg_src_i,
  output logic              any_evt_o,
  output logic              cold_q_o,
  output logic              reload_q_o,
  output src_t              cur_src_o
);

  logic cold_evt;
  logic warm_evt;
  logic [N_WARM:0] warm_or;

  // OR chain over the warm causes
  assign warm_or[0] = 1'b0;
  for (genvar g = 0; g < N_WARM; g++) begin : g_warm
    assign warm_or[g+1] = warm_or[g] | warm_i[g];
  end

  assign cold_evt  = por_i | bor_i | ~supply_ok_i;
  assign warm_evt  = warm_or[N_WARM];
  assign any_evt_o = cold_evt | warm_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cold_q_o   <= 1'b1;
      reload_q_o <= 1'b1;
      cur_src_o  <= '0;
    end else if (cold_evt) begin
      cold_q_o   <= 1'b1;
      reload_q_o <= 1'b1;
    end else if (warm_evt) begin
      // a pending cold reload keeps its class
      cold_q_o   <= reload_q_o;
    end else if (load_i) begin
      reload_q_o <= 1'b0;
      if (reload_q_o) cur_src_o <= cfg_src_i;
    end
  end

  // R1: a cold cause marks the reset cold and arms the reload
  p_cold_arms_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_evt |=> (cold_q_o && reload_q_o));

  // R1: the load takes the configured source
  p_load_cfg_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && reload_q_o && !any_evt_o) |=> (cur_src_o == $past(cfg_src_i)));

  // R2: a plain warm reset keeps the source and reports warm
  p_warm_keeps_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_evt && !cold_evt && !reload_q_o) |=> (!cold_q_o && $stable(cur_src_o)));

  // R3: a warm cause cannot cancel a pending cold reload
  p_pending_cold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_evt && reload_q_o) |=> (cold_q_o && reload_q_o));

endmodule

// File: rtl/rcs_phase_timer.sv
module rcs_phase_timer #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = step_i && (cnt_q == (limit_i - CNT_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  // R10: the count never runs past the limit of the phase it serves
  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < limit_i);

endmodule

// File: rtl/rstclk_sequencer.sv
module rstclk_sequencer import rcs_pkg::*; #(
  parameter int unsigned N_WARM     = 4,
  parameter int unsigned OSCD_TICKS = 8,
  parameter int unsigned OST_EDGES  = 1024,
  parameter int unsigned LOCK_TICKS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic              bor_i,
  input  logic [N_WARM-1:0] warm_i,
  input  logic              supply_ok_i,
  input  logic [2:0]        cfg_src_i,
  input  logic              prim_xtal_i,
  input  logic              ref_tick_i,
  input  logic              osc_edge_i,
  output logic              sys_rst_o,
  output logic [2:0]        cur_src_o,
  output logic              cold_rst_o
);

  localparam int unsigned MAX_A   = (OSCD_TICKS > LOCK_TICKS) ? OSCD_TICKS : LOCK_TICKS;
  localparam int unsigned MAX_LEN = (MAX_A > OST_EDGES) ? MAX_A : OST_EDGES;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  phase_e           phase_q, phase_d;
  logic             any_evt;
  logic             reload_q;
  logic             load;
  logic             t_clear, t_step, t_done;
  logic [CNT_W-1:0] t_limit;
  src_t             src_q;

  assign load = !any_evt && (phase_q == PH_SUPPLY);

  rcs_cause_ctl #(.N_WARM(N_WARM)) u_cause (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .por_i       (por_i),
    .bor_i       (bor_i),
    .supply_ok_i (supply_ok_i),
    .warm_i      (warm_i),
    .load_i      (load),
    .cfg_src_i   (cfg_src_i),
    .any_evt_o   (any_evt),
    .cold_q_o    (cold_rst_o),
    .reload_q_o  (reload_q),
    .cur_src_o   (src_q)
  );

  assign cur_src_o = src_q;

  // select what the shared counter measures in each phase
  always_comb begin
    t_limit = CNT_W'(1);
    t_step  = 1'b0;
    unique case (phase_q)
      PH_OSCD: begin t_limit = CNT_W'(OSCD_TICKS); t_step = ref_tick_i; end
      PH_OST:  begin t_limit = CNT_W'(OST_EDGES);  t_step = osc_edge_i; end
      PH_LOCK: begin t_limit = CNT_W'(LOCK_TICKS); t_step = ref_tick_i; end
      default: ;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    if (any_evt) begin
      phase_d = PH_SUPPLY;
    end else begin
      unique case (phase_q)
        PH_SUPPLY: phase_d = PH_OSCD;
        PH_OSCD: if (t_done) begin
          if (src_uses_ost(src_q, prim_xtal_i)) phase_d = PH_OST;
          else if (src_uses_pll(src_q))         phase_d = PH_LOCK;
          else                                  phase_d = PH_RUN;
        end
        PH_OST: if (t_done) begin
          if (src_uses_pll(src_q)) phase_d = PH_LOCK;
          else                     phase_d = PH_RUN;
        end
        PH_LOCK: if (t_done) phase_d = PH_RUN;
        default: phase_d = PH_RUN;
      endcase
    end
  end

  assign t_clear = any_evt || (phase_d != phase_q) || (phase_q == PH_SUPPLY);

  rcs_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (t_clear),
    .step_i  (t_step),
    .limit_i (t_limit),
    .done_o  (t_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_SUPPLY;
      sys_rst_o <= 1'b1;
    end else begin
      phase_q   <= phase_d;
      sys_rst_o <= (phase_d != PH_RUN);
    end
  end

  // R4: any reset cause holds the system in reset on the next edge
  p_evt_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_evt |=> sys_rst_o);

  // R4: release only follows a cycle with good supply
  p_release_supply_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> $past(supply_ok_i));

  // R7: the lock wait is entered only for PLL sources
  p_lock_pll_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_LOCK) |-> src_uses_pll(src_q));

  // R9: the source used by the delay chain is loaded before counting starts
  p_no_count_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_SUPPLY) |-> !reload_q);

endmodule

// File: tb/rstclk_sequencer_tb_top.sv
`timescale 1ns/1ps
module rstclk_sequencer_tb_top;

  localparam int OSCD = 3;
  localparam int OST  = 1024;
  localparam int LOCK = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por = 1'b0, bor = 1'b0;
  logic [3:0] warm = '0;
  logic       supply = 1'b1;
  logic [2:0] cfg = 3'd6;
  logic       xtal = 1'b0;
  logic       rtick = 1'b0, oedge = 1'b0;
  logic       sys_rst;
  logic [2:0] cur_src;
  logic       cold;

  always #2 clk = ~clk;

  rstclk_sequencer #(.N_WARM(4), .OSCD_TICKS(OSCD), .OST_EDGES(OST), .LOCK_TICKS(LOCK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .por_i(por), .bor_i(bor), .warm_i(warm),
    .supply_ok_i(supply), .cfg_src_i(cfg), .prim_xtal_i(xtal),
    .ref_tick_i(rtick), .osc_edge_i(oedge),
    .sys_rst_o(sys_rst), .cur_src_o(cur_src), .cold_rst_o(cold)
  );

  int total = 0;
  int bad   = 0;

  typedef struct { logic [2:0] src; logic cold; string tag; } exp_t;
  exp_t sb_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_ref();
    @(negedge clk) rtick = 1'b1;
    @(negedge clk) rtick = 1'b0;
  endtask

  task automatic pulse_osc();
    @(negedge clk) oedge = 1'b1;
    @(negedge clk) oedge = 1'b0;
  endtask

  // kind: 0 por, 1 bor, 2 software warm cause, 3 por and warm together
  task automatic fire(input int kind, input string req);
    @(negedge clk);
    case (kind)
      0: por = 1'b1;
      1: bor = 1'b1;
      2: warm[2] = 1'b1;
      default: begin por = 1'b1; warm[0] = 1'b1; end
    endcase
    @(negedge clk);
    por = 1'b0; bor = 1'b0; warm = '0;
    chk(sys_rst == 1'b1, req, "reset held after event", sys_rst, 1);
  endtask

  task automatic expect_rel(input logic [2:0] s, input logic c, input string tag);
    exp_t e;
    e.src = s; e.cold = c; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic run_phases(input bit ost, input bit pll, input string tag);
    for (int i = 0; i < OSCD; i++) begin
      if (i == 0) pulse_osc();   // R10: ignored in the start-up delay
      if (i == OSCD - 1) chk(sys_rst == 1'b1, "R10", "held before last delay tick", sys_rst, 1);
      pulse_ref();
    end
    if (ost) begin
      chk(sys_rst == 1'b1, tag, "held into start-up timer", sys_rst, 1);
      pulse_ref();               // R10: ignored in the start-up timer
      for (int i = 0; i < OST; i++) begin
        if (i == OST - 1) chk(sys_rst == 1'b1, "R10", "held before last osc edge", sys_rst, 1);
        pulse_osc();
      end
    end
    if (pll) begin
      chk(sys_rst == 1'b1, tag, "held into lock wait", sys_rst, 1);
      pulse_osc();               // R10: ignored in the lock wait
      for (int i = 0; i < LOCK; i++) begin
        if (i == LOCK - 1) chk(sys_rst == 1'b1, "R10", "held before last lock tick", sys_rst, 1);
        pulse_ref();
      end
    end
    chk(sys_rst == 1'b0, tag, "released after final strobe", sys_rst, 0);
  endtask

  // monitor: on every release compare against the scoreboard
  logic prev_rst = 1'b1;
  always @(negedge clk) begin
    if (rst_n && prev_rst && !sys_rst) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R8", "release with nothing expected", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(cur_src == e.src, e.tag, "source at release", cur_src, e.src);
        chk(cold == e.cold, e.tag, "cold flag at release", cold, e.cold);
      end
    end
    prev_rst = sys_rst;
  end

  bit finished = 1'b0;

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9: reset values, then the first sequence loads the configuration
    repeat (3) @(negedge clk);
    chk(sys_rst == 1'b1, "R9", "sys_rst in reset", sys_rst, 1);
    chk(cold == 1'b1, "R9", "cold in reset", cold, 1);
    chk(cur_src == 3'd0, "R9", "source in reset", cur_src, 0);
    @(negedge clk) rst_n = 1'b1;
    expect_rel(3'd6, 1'b1, "R9");
    run_phases(1'b0, 1'b0, "R9");

    // R1 R5: cold via power-on, fast RC, delay only
    cfg = 3'd0; fire(0, "R4"); expect_rel(3'd0, 1'b1, "R1"); run_phases(1'b0, 1'b0, "R5");

    // R2: warm keeps source despite new configuration
    cfg = 3'd5; fire(2, "R4"); expect_rel(3'd0, 1'b0, "R2"); run_phases(1'b0, 1'b0, "R5");

    // R6: primary crystal adds the start-up timer
    cfg = 3'd2; xtal = 1'b1; fire(1, "R4"); expect_rel(3'd2, 1'b1, "R6"); run_phases(1'b1, 1'b0, "R6");

    // R5: primary as external clock, delay only
    xtal = 1'b0; fire(0, "R4"); expect_rel(3'd2, 1'b1, "R5"); run_phases(1'b0, 1'b0, "R5");

    // R6: secondary crystal
    cfg = 3'd4; fire(0, "R4"); expect_rel(3'd4, 1'b1, "R6"); run_phases(1'b1, 1'b0, "R6");

    // R7: fast RC with PLL, lock only
    cfg = 3'd1; fire(1, "R4"); expect_rel(3'd1, 1'b1, "R7"); run_phases(1'b0, 1'b1, "R7");

    // R2 R7: warm keeps the PLL source
    cfg = 3'd0; fire(2, "R4"); expect_rel(3'd1, 1'b0, "R2"); run_phases(1'b0, 1'b1, "R7");

    // R7: primary crystal with PLL, timer then lock
    cfg = 3'd3; xtal = 1'b1; fire(0, "R4"); expect_rel(3'd3, 1'b1, "R7"); run_phases(1'b1, 1'b1, "R7");

    // R3: cold and warm in the same cycle
    cfg = 3'd7; fire(3, "R3"); expect_rel(3'd7, 1'b1, "R3"); run_phases(1'b0, 1'b0, "R3");

    // R3: warm during pending cold reload
    cfg = 3'd5;
    @(negedge clk) por = 1'b1;
    @(negedge clk) begin por = 1'b0; warm[1] = 1'b1; end
    @(negedge clk) warm = '0;
    chk(cold == 1'b1, "R3", "cold kept over warm while pending", cold, 1);
    expect_rel(3'd5, 1'b1, "R3");
    run_phases(1'b0, 1'b0, "R3");

    // R8: restart mid start-up delay by a warm event
    cfg = 3'd0; fire(0, "R4");
    pulse_ref(); pulse_ref();
    fire(2, "R8");
    expect_rel(3'd0, 1'b0, "R8");
    run_phases(1'b0, 1'b0, "R8");

    // R8: event coinciding with the last delay tick
    cfg = 3'd6; fire(0, "R4");
    for (int i = 0; i < OSCD - 1; i++) pulse_ref();
    @(negedge clk) begin rtick = 1'b1; por = 1'b1; end
    @(negedge clk) begin rtick = 1'b0; por = 1'b0; end
    chk(sys_rst == 1'b1, "R8", "event beats final tick", sys_rst, 1);
    expect_rel(3'd6, 1'b1, "R8");
    run_phases(1'b0, 1'b0, "R8");

    // R4 R10: supply loss holds reset; ticks ignored meanwhile
    cfg = 3'd5;
    @(negedge clk) supply = 1'b0;
    for (int i = 0; i < 4; i++) pulse_ref();
    chk(sys_rst == 1'b1, "R4", "held while supply low", sys_rst, 1);
    chk(cold == 1'b1, "R4", "supply loss is cold", cold, 1);
    @(negedge clk) supply = 1'b1;
    expect_rel(3'd5, 1'b1, "R1");
    run_phases(1'b0, 1'b0, "R10");

    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R8", "all expected releases seen", sb_q.size(), 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule